// File: doc/BRIEF.md
# Blocking Write-Back Data Cache Controller

This block sits between a processor's load/store port and a slower main memory and holds a direct-mapped data cache of 1024 lines. Each line holds four 32-bit words, so the cache holds 16 KiB. The processor presents one word-sized read or write with a byte address. The controller compares the stored tag for the addressed line. On a hit it completes the access at once. On a write hit it updates only the cached copy and marks the line modified.

On a miss the controller first looks at the line it is about to replace. If that line is valid and modified, it sends the whole line back to memory at the address rebuilt from the line's stored tag. It then reads the requested line from memory as one 128-bit transfer. Last, it returns to the tag compare, where the access now hits. A write miss therefore allocates the line and merges the written word into it. The processor is held off, with its ready low, until its own access finishes.

Both sides use a valid/ready handshake. The memory may take any number of cycles to answer a request. The tag, data and status storage all live inside the block.

Top module: `wbc_top`

## Requirements
- R1: After reset, no line is valid and none is modified, so the first access to any address makes a memory read. `cpu_ready` and `mem_valid` are 0 while in reset.
- R2: The byte address splits as follows: tag = bits 31:14, line index = bits 13:4, word select = bits 3:2. Bits 1:0 have no effect on which word is read or written.
- R3: A read hit raises `cpu_ready` for exactly one cycle, one clock after the request is seen, with the selected word on `cpu_rdata`. It makes no memory request.
- R4: A write hit replaces only the selected word of the cached line and marks the line modified. It makes no memory request.
- R5: A miss whose victim line is invalid or unmodified makes exactly one memory read (`mem_we`=0). The read address is {request tag, index, 4'b0000}, and no memory write takes place.
- R6: A miss whose victim line is valid and modified first makes one memory write (`mem_we`=1) and only then the line read. The write address is {victim's stored tag, index, 4'b0000} and the write data is the whole victim line, with word 0 in bits 31:0.
- R7: A write miss allocates the line. The fetched line, with the written word merged in, is kept as modified, so its later eviction writes back the merged line.
- R8: `cpu_ready` is never high while a memory request is open, and it is only a one-cycle pulse.
- R9: A memory request keeps `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until `mem_ready` is seen. After an accepted write-back, the next request is the line read for the same index.
- R10: A line filled by a read miss starts unmodified, so evicting it without a later write makes no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present; held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access complete (one-cycle pulse) |
| mem_valid | output | 1 | Memory request open |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | 32 | Line-aligned memory byte address |
| mem_wdata | output | 128 | Line written back |
| mem_rdata | input | 128 | Line returned by memory, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the open request |

## Verification
The checker watches the handshakes on every cycle. It checks that a ready pulse never overlaps an open memory request and lasts one cycle, that a memory request holds its controls steady until accepted, and that an accepted write-back is followed by a line read for the same index. Only the bench scenarios can show the effects that depend on stored contents. These are that hits bypass memory, that the write-back carries the victim's old tag and merged words, that the allocate-and-merge of a write miss works, and that a freshly read line evicts without a write. The bench compares these against its own model of memory.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    localparam int ADDR_W    = 32;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 4;
    localparam int NUM_SETS  = 1024;

    localparam int BLK_W  = WORD_W * BLK_WORDS;
    localparam int OFF_W  = $clog2(BLK_WORDS * WORD_W / 8);
    localparam int WSEL_W = $clog2(BLK_WORDS);
    localparam int BSEL_W = OFF_W - WSEL_W;
    localparam int IDX_W  = $clog2(NUM_SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMP   = 2'd1,
        ST_WB    = 2'd2,
        ST_ALLOC = 2'd3
    } wbc_state_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] wsel;
        logic [BSEL_W-1:0] bsel;
    } wbc_addr_t;

    function automatic logic [ADDR_W-1:0] line_base(
        input logic [TAG_W-1:0] tag,
        input logic [IDX_W-1:0] idx
    );
        return {tag, idx, {OFF_W{1'b0}}};
    endfunction

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
    parameter int SETS = wbc_pkg::NUM_SETS,
    parameter int TW   = wbc_pkg::TAG_W,
    localparam int IW  = $clog2(SETS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] idx,
    input  logic          fill_en,
    input  logic [TW-1:0] fill_tag,
    input  logic          mark_dirty,
    output logic          line_valid,
    output logic          line_dirty,
    output logic [TW-1:0] line_tag
);

    logic [SETS-1:0] valid_q;
    logic [SETS-1:0] dirty_q;
    logic [TW-1:0]   tag_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx] <= fill_tag;
        end
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];

endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
    parameter int SETS  = wbc_pkg::NUM_SETS,
    parameter int WW    = wbc_pkg::WORD_W,
    parameter int WORDS = wbc_pkg::BLK_WORDS,
    localparam int IW   = $clog2(SETS),
    localparam int SW   = $clog2(WORDS),
    localparam int BW   = WW * WORDS
) (
    input  logic          clk,
    input  logic [IW-1:0] idx,
    input  logic          fill_en,
    input  logic [BW-1:0] fill_line,
    input  logic          word_we,
    input  logic [SW-1:0] wsel,
    input  logic [WW-1:0] wdata,
    output logic [BW-1:0] line_out,
    output logic [WW-1:0] word_out
);

    logic [BW-1:0] line_q [SETS];
    logic [WW-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        if (fill_en) begin
            line_q[idx] <= fill_line;
        end else if (word_we) begin
            line_q[idx][wsel*WW +: WW] <= wdata;
        end
    end

    assign line_out = line_q[idx];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign words[g] = line_out[g*WW +: WW];
    end

    assign word_out = words[wsel];

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_valid,
    input  logic       cpu_we,
    input  logic       hit,
    input  logic       victim_dirty,
    input  logic       mem_ready,
    output wbc_state_e state,
    output logic       cpu_ready,
    output logic       mem_valid,
    output logic       mem_we,
    output logic       fill_en,
    output logic       word_we
);

    wbc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cpu_valid) state_d = ST_CMP;
            ST_CMP: begin
                if (hit)               state_d = ST_IDLE;
                else if (victim_dirty) state_d = ST_WB;
                else                   state_d = ST_ALLOC;
            end
            ST_WB:    if (mem_ready) state_d = ST_ALLOC;
            ST_ALLOC: if (mem_ready) state_d = ST_CMP;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state     = state_q;
    assign cpu_ready = (state_q == ST_CMP) && hit;
    assign word_we   = cpu_ready && cpu_we;
    assign mem_valid = (state_q == ST_WB) || (state_q == ST_ALLOC);
    assign mem_we    = (state_q == ST_WB);
    assign fill_en   = (state_q == ST_ALLOC) && mem_ready;

endmodule

// File: rtl/wbc_top.sv
module wbc_top
    import wbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]  mem_wdata,
    input  logic [BLK_W-1:0]  mem_rdata,
    input  logic              mem_ready
);

    wbc_addr_t         req;
    wbc_state_e        state;
    logic              line_valid, line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic              hit, victim_dirty;
    logic              fill_en, word_we;
    logic [BLK_W-1:0]  line_out;

    assign req          = wbc_addr_t'(cpu_addr);
    assign hit          = line_valid && (line_tag == req.tag);
    assign victim_dirty = line_valid && line_dirty;

    wbc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cpu_valid    (cpu_valid),
        .cpu_we       (cpu_we),
        .hit          (hit),
        .victim_dirty (victim_dirty),
        .mem_ready    (mem_ready),
        .state        (state),
        .cpu_ready    (cpu_ready),
        .mem_valid    (mem_valid),
        .mem_we       (mem_we),
        .fill_en      (fill_en),
        .word_we      (word_we)
    );

    wbc_tag_store #(.SETS(NUM_SETS), .TW(TAG_W)) u_tags (
        .clk        (clk),
        .rst        (rst),
        .idx        (req.idx),
        .fill_en    (fill_en),
        .fill_tag   (req.tag),
        .mark_dirty (word_we),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag)
    );

    wbc_data_store #(.SETS(NUM_SETS), .WW(WORD_W), .WORDS(BLK_WORDS)) u_data (
        .clk       (clk),
        .idx       (req.idx),
        .fill_en   (fill_en),
        .fill_line (mem_rdata),
        .word_we   (word_we),
        .wsel      (req.wsel),
        .wdata     (cpu_wdata),
        .line_out  (line_out),
        .word_out  (cpu_rdata)
    );

    assign mem_addr  = (state == ST_WB) ? line_base(line_tag, req.idx)
                                        : line_base(req.tag, req.idx);
    assign mem_wdata = line_out;

endmodule

// File: rtl/wbc_chk.sv
module wbc_chk
    import wbc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_valid,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [WORD_W-1:0] cpu_wdata,
    input logic [WORD_W-1:0] cpu_rdata,
    input logic              cpu_ready,
    input logic              mem_valid,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BLK_W-1:0]  mem_wdata,
    input logic [BLK_W-1:0]  mem_rdata,
    input logic              mem_ready
);

    // R8
    ready_vs_mem_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_valid);

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we)
            && $stable(mem_addr) && $stable(mem_wdata)));

    // R6
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_we && mem_ready) |=> (mem_valid && !mem_we
            && (mem_addr[13:4] == $past(mem_addr[13:4]))));

    // R5
    fill_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_we && mem_ready) |=> !mem_valid);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!cpu_ready && !mem_valid));

endmodule

bind wbc_top wbc_chk u_chk (.*);

// File: tb/sim_wbc_top.sv
module sim_wbc_top;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;

    logic         clk = 1'b0;
    logic         rst;
    logic         cpu_valid, cpu_we;
    logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata;
    logic         cpu_ready;
    logic         mem_valid, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata, mem_rdata;
    logic         mem_ready;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbc_top u0 (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // ---------------- memory model ----------------
    logic [127:0] bmem [logic [31:0]];
    int           lat_cnt;
    int           n_fetch = 0, n_wb = 0, seq = 0, fetch_seq = 0, wb_seq = 0;
    logic [31:0]  fetch_addr, wb_addr;
    logic [127:0] wb_data;

    function automatic logic [31:0] dflt(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC3A5_0F00;
    endfunction

    function automatic logic [127:0] dflt_line(input logic [31:0] base);
        logic [127:0] l;
        for (int i = 0; i < 4; i++) l[i*32 +: 32] = dflt(base + 32'(i*4));
        return l;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ready <= 1'b0;
            lat_cnt   <= 0;
            mem_rdata <= '0;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            lat_cnt   <= 0;
        end else if (mem_valid) begin
            if (lat_cnt == MEM_LAT) begin
                mem_ready <= 1'b1;
                seq = seq + 1;
                if (mem_we) begin
                    bmem[mem_addr & ~32'hF] = mem_wdata;
                    n_wb    = n_wb + 1;
                    wb_addr = mem_addr;
                    wb_data = mem_wdata;
                    wb_seq  = seq;
                end else begin
                    mem_rdata  <= bmem.exists(mem_addr & ~32'hF) ?
                                  bmem[mem_addr & ~32'hF] : dflt_line(mem_addr & ~32'hF);
                    n_fetch    = n_fetch + 1;
                    fetch_addr = mem_addr;
                    fetch_seq  = seq;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int waits);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        waits = 0;
        do begin
            @(negedge clk);
            waits++;
        end while (!cpu_ready && waits < 1000);
        rd = cpu_rdata;
        @(negedge clk);
        cpu_valid = 1'b0; cpu_we = 1'b0;
    endtask

    localparam logic [31:0] A = 32'h0000_1230;
    localparam logic [31:0] B = 32'h0000_5230;
    localparam logic [31:0] C = 32'h0000_9230;
    localparam logic [31:0] D = 32'h0000_1240;

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(cpu_ready == 1'b0, "R1 ready after reset", 128'(cpu_ready), 0);
        check(mem_valid == 1'b0, "R1 mem_valid after reset", 128'(mem_valid), 0);
    endtask

    task automatic t_read_miss();
        logic [31:0] rd; int w; int f0 = n_fetch, b0 = n_wb;
        access(0, A + 32'h4, 0, rd, w);
        check(rd == dflt(A + 32'h4), "R1 cold read data", 128'(rd), 128'(dflt(A + 32'h4)));
        check(n_fetch == f0 + 1, "R5 one line read", 128'(n_fetch - f0), 1);
        check(n_wb == b0, "R5 no write-back", 128'(n_wb - b0), 0);
        check(fetch_addr == A, "R5 line read address", 128'(fetch_addr), 128'(A));
    endtask

    task automatic t_read_hit();
        logic [31:0] rd; int w; int f0 = n_fetch;
        access(0, A + 32'hB, 0, rd, w);   // bits 1:0 = 3, word 2
        check(rd == dflt(A + 32'h8), "R2 byte bits ignored", 128'(rd), 128'(dflt(A + 32'h8)));
        check(w == 1, "R3 hit latency", 128'(w), 1);
        check(n_fetch == f0, "R3 hit no memory", 128'(n_fetch - f0), 0);
    endtask

    task automatic t_write_hit();
        logic [31:0] rd; int w; int f0 = n_fetch, b0 = n_wb;
        access(1, A + 32'hE, 32'hDEAD_BEEF, rd, w);
        check(w == 1, "R4 write hit latency", 128'(w), 1);
        access(0, A + 32'hC, 0, rd, w);
        check(rd == 32'hDEAD_BEEF, "R4 written word", 128'(rd), 128'(32'hDEAD_BEEF));
        access(0, A + 32'h8, 0, rd, w);
        check(rd == dflt(A + 32'h8), "R4 neighbour word kept", 128'(rd), 128'(dflt(A + 32'h8)));
        check(n_fetch == f0 && n_wb == b0, "R4 no memory traffic",
              128'(n_fetch - f0 + n_wb - b0), 0);
    endtask

    task automatic t_dirty_evict();
        logic [31:0] rd; int w; int b0 = n_wb;
        logic [127:0] exp_l;
        exp_l = dflt_line(A);
        exp_l[127:96] = 32'hDEAD_BEEF;
        access(0, B, 0, rd, w);
        check(n_wb == b0 + 1, "R6 one write-back", 128'(n_wb - b0), 1);
        check(wb_addr == A, "R6 victim address", 128'(wb_addr), 128'(A));
        check(wb_data == exp_l, "R6 victim line", wb_data, exp_l);
        check(wb_seq < fetch_seq, "R6 write-back before read", 128'(wb_seq), 128'(fetch_seq));
        check(fetch_addr == B, "R6 new line address", 128'(fetch_addr), 128'(B));
        check(rd == dflt(B), "R6 new line data", 128'(rd), 128'(dflt(B)));
    endtask

    task automatic t_clean_evict();
        logic [31:0] rd; int w; int b0 = n_wb;
        access(0, A + 32'hC, 0, rd, w);
        check(n_wb == b0, "R10 clean victim not written", 128'(n_wb - b0), 0);
        check(rd == 32'hDEAD_BEEF, "R6 memory holds written-back word", 128'(rd),
              128'(32'hDEAD_BEEF));
    endtask

    task automatic t_write_miss();
        logic [31:0] rd; int w; int f0 = n_fetch, b0 = n_wb;
        logic [127:0] exp_l;
        access(1, C + 32'h4, 32'h1234_5678, rd, w);
        check(n_fetch == f0 + 1 && n_wb == b0, "R7 write miss allocates",
              128'(n_fetch - f0), 1);
        access(0, C + 32'h4, 0, rd, w);
        check(rd == 32'h1234_5678 && w == 1, "R7 merged word hits", 128'(rd),
              128'(32'h1234_5678));
        access(0, C + 32'h8, 0, rd, w);
        check(rd == dflt(C + 32'h8), "R7 fetched words kept", 128'(rd), 128'(dflt(C + 32'h8)));
        exp_l = dflt_line(C);
        exp_l[63:32] = 32'h1234_5678;
        access(0, A, 0, rd, w);
        check(n_wb == b0 + 1 && wb_addr == C, "R7 allocated line dirty", 128'(wb_addr), 128'(C));
        check(wb_data == exp_l, "R7 merged line written back", wb_data, exp_l);
    endtask

    task automatic t_index_sep();
        logic [31:0] rd; int w; int f0;
        access(0, D, 0, rd, w);
        check(fetch_addr == D && rd == dflt(D), "R2 neighbour index read", 128'(rd), 128'(dflt(D)));
        f0 = n_fetch;
        access(0, A + 32'h4, 0, rd, w);
        check(n_fetch == f0 && w == 1, "R2 other index undisturbed", 128'(n_fetch - f0), 0);
    endtask

    initial begin
        rst = 1'b1; cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_read_miss();
        t_read_hit();
        t_write_hit();
        t_dirty_evict();
        t_clean_evict();
        t_write_miss();
        t_index_sep();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule